// File: doc/BRIEF.md
# Count/Compare Timer Interrupt

This block keeps a 32-bit up-counter that advances by one on every enabled tick of a fixed-rate tick strobe (nominally 100 MHz), holds a 32-bit compare value, and raises a timer interrupt when the incremented count equals that compare value. The interrupt stays pending until software writes the compare register, which is the acknowledge.

Software can load the counter directly at any time. It can freeze counting with a hold control, and it can steer the interrupt onto one of eight request lines with a 3-bit routing field. A configuration input decides whether the pending state is also shown on a status output, or whether only the request line carries it.

Top module: `cct_timer_top`

## Requirements
- R1: After reset the count output reads 1, the compare value is 0, the pending output is 0 and all eight request lines are 0.
- R2: In a cycle with `tick_i`=1, `hold_i`=0 and no count write, the count output shows the old count plus one after the next rising edge.
- R3: While `hold_i`=1 and no count write occurs, the count stays unchanged and no new pending interrupt is raised.
- R4: A count write (`cnt_we_i`=1) loads `cnt_wdata_i` at the next edge, whether the count is held or ticking, and the load by itself never raises the interrupt.
- R5: When an enabled increment produces a value equal to the compare value, the interrupt becomes pending after that edge, and request line `irq_o[n]` is asserted, with n the routing value.
- R6: The count wraps from 0xFFFFFFFF to 0x00000000, and a compare value of 0 matches that wrapping increment.
- R7: A compare write clears the pending interrupt at the next edge. It wins over a match in the same cycle, so the interrupt stays clear.
- R8: `irq_o` is all zeros when nothing is pending. Otherwise exactly bit n is set, with n the value of `route_i` sampled at the previous edge, so a routing change while pending moves the request one cycle later.
- R9: With `stat_en_i`=0 the pending output reads 0 while the request line is still driven. With `stat_en_i`=1 the pending output shows the pending state.
- R10: Once pending, the interrupt stays pending through further ticks, holds and count writes until a compare write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Fixed-rate count strobe |
| hold_i | input | 1 | Freezes counting and interrupt generation |
| cnt_we_i | input | 1 | Count register write enable |
| cnt_wdata_i | input | 32 | Count write value |
| cmp_we_i | input | 1 | Compare register write enable (acknowledge) |
| cmp_wdata_i | input | 32 | Compare write value |
| route_i | input | 3 | Request line index 0..7 |
| stat_en_i | input | 1 | Makes the pending state visible on `pend_o` |
| count_o | output | 32 | Current count |
| pend_o | output | 1 | Pending timer interrupt (gated by `stat_en_i`) |
| irq_o | output | 8 | Interrupt request lines, at most one set |

## Verification
The bench targets the wrap from all-ones to zero against a compare of zero. A design that compared the old count, or dropped the carry case, would miss that interrupt. It drives a compare write in the same cycle as a match; a design with the wrong priority would leave the interrupt pending after the acknowledge. It checks that a held counter neither moves nor raises an interrupt, and that a count load landing on the compare value raises nothing. It also changes the routing field while an interrupt is pending: a design that routed without the register stage would move the line one cycle early, and one that latched the route only when the interrupt fired would never move it.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int CCT_CNT_W = 32;
  localparam int CCT_LINES = 8;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_STEP = 2'd1,
    SRC_LOAD = 2'd2
  } cnt_src_e;
endpackage

// File: rtl/cct_counter.sv
module cct_counter
  import cct_pkg::*;
#(
  parameter int W = CCT_CNT_W,
  parameter logic [W-1:0] RST_VAL = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         hold_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] next_o,
  output logic         step_o
);
  function automatic logic [W-1:0] bump(input logic [W-1:0] v);
    return v + W'(1);
  endfunction

  cnt_src_e     src;
  logic [W-1:0] count_q;

  always_comb begin
    if (we_i)                 src = SRC_LOAD;
    else if (tick_i && !hold_i) src = SRC_STEP;
    else                      src = SRC_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= RST_VAL;
    else begin
      case (src)
        SRC_LOAD: count_q <= wdata_i;
        SRC_STEP: count_q <= bump(count_q);
        default:  count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;
  assign next_o  = bump(count_q);
  assign step_o  = (src == SRC_STEP);

  // R2
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !hold_i && !we_i) |=> count_o == $past(count_o) + W'(1));
  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !we_i) |=> $stable(count_o));
  // R4
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> count_o == $past(wdata_i));
endmodule

// File: rtl/cct_compare.sv
module cct_compare
  import cct_pkg::*;
#(
  parameter int W = CCT_CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         step_i,
  input  logic [W-1:0] next_i,
  output logic         match_o,
  output logic         pend_o
);
  function automatic logic hit(input logic step, input logic [W-1:0] nxt,
                               input logic [W-1:0] ref_v);
    return step && (nxt == ref_v);
  endfunction

  logic [W-1:0] cmp_q;
  logic         pend_q;

  assign match_o = hit(step_i, next_i, cmp_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (we_i) cmp_q <= wdata_i;
      if (we_i)         pend_q <= 1'b0;
      else if (match_o) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;

  // R7
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> !pend_o);
  // R5
  a_r5_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !we_i) |=> pend_o);
  // R10
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !we_i) |=> pend_o);
  // R3 / R4: without an enabled increment nothing new becomes pending
  a_r3_no_new: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !step_i) |=> !pend_o);
endmodule

// File: rtl/cct_router.sv
module cct_router
  import cct_pkg::*;
#(
  parameter int LINES = CCT_LINES,
  parameter int SW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    sel_i,
  input  logic             pend_i,
  output logic [LINES-1:0] irq_o
);
  logic [SW-1:0] route_q;

  always_ff @(posedge clk) begin
    if (!rst_n) route_q <= '0;
    else        route_q <= sel_i;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign irq_o[g] = pend_i && (route_q == SW'(g));
  end

  // R8
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));
  // R8
  a_r8_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i && $past(pend_i)) |-> irq_o == (LINES'(1) << $past(sel_i)));
  // R8
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_i |-> irq_o == '0);
endmodule

// File: rtl/cct_timer_top.sv
module cct_timer_top
  import cct_pkg::*;
#(
  parameter int W = CCT_CNT_W,
  parameter int LINES = CCT_LINES,
  localparam int SW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             cnt_we_i,
  input  logic [W-1:0]     cnt_wdata_i,
  input  logic             cmp_we_i,
  input  logic [W-1:0]     cmp_wdata_i,
  input  logic [SW-1:0]    route_i,
  input  logic             stat_en_i,
  output logic [W-1:0]     count_o,
  output logic             pend_o,
  output logic [LINES-1:0] irq_o
);
  logic [W-1:0] next_w;
  logic         step_w;
  logic         match_w;
  logic         pend_w;

  cct_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold_i),
    .we_i(cnt_we_i), .wdata_i(cnt_wdata_i),
    .count_o(count_o), .next_o(next_w), .step_o(step_w)
  );

  cct_compare #(.W(W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .we_i(cmp_we_i), .wdata_i(cmp_wdata_i),
    .step_i(step_w), .next_i(next_w), .match_o(match_w), .pend_o(pend_w)
  );

  cct_router #(.LINES(LINES)) u_rte (
    .clk(clk), .rst_n(rst_n), .sel_i(route_i), .pend_i(pend_w), .irq_o(irq_o)
  );

  assign pend_o = stat_en_i & pend_w;

  // R9: request line and status agree whenever status is enabled
  a_r9_status: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en_i |-> (pend_o == (irq_o != '0)));
  // R6: an all-ones count that steps lands on zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step_w && count_o == '1) |=> count_o == '0);
endmodule

// File: tb/sim_cct_timer_top.sv
module sim_cct_timer_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0, hold_i = 1'b0, cnt_we_i = 1'b0, cmp_we_i = 1'b0;
  logic [31:0] cnt_wdata_i = '0, cmp_wdata_i = '0;
  logic [2:0]  route_i = '0;
  logic        stat_en_i = 1'b1;
  logic [31:0] count_o;
  logic        pend_o;
  logic [7:0]  irq_o;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_count, m_cmp;
  logic        m_pend;

  always #5 clk = ~clk;

  cct_timer_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .hold_i(hold_i),
    .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
    .cmp_we_i(cmp_we_i), .cmp_wdata_i(cmp_wdata_i),
    .route_i(route_i), .stat_en_i(stat_en_i),
    .count_o(count_o), .pend_o(pend_o), .irq_o(irq_o)
  );

  function automatic logic [7:0] exp_lines(input logic p, input logic [2:0] r);
    logic [7:0] v = '0;
    if (p) v[r] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] exp_count(input logic [31:0] c, input logic we,
      input logic [31:0] wd, input logic tk, input logic hd);
    if (we) return wd;
    if (tk && !hd) return c + 32'd1;
    return c;
  endfunction

  task automatic check(input string tag, input logic [31:0] ec, input logic ep,
                       input logic [7:0] ei);
    checks++;
    if (count_o !== ec || pend_o !== ep || irq_o !== ei) begin
      errors++;
      $display("FAIL %s: count=%h pend=%b irq=%b expected count=%h pend=%b irq=%b",
               tag, count_o, pend_o, irq_o, ec, ep, ei);
    end
  endtask

  task automatic cyc(input logic tk, input logic hd, input logic cwe,
                     input logic [31:0] cwd, input logic mwe, input logic [31:0] mwd,
                     input logic [2:0] rt, input logic vis, input string tag);
    logic hit;
    @(negedge clk);
    tick_i = tk; hold_i = hd; cnt_we_i = cwe; cnt_wdata_i = cwd;
    cmp_we_i = mwe; cmp_wdata_i = mwd; route_i = rt; stat_en_i = vis;
    hit = tk && !hd && !cwe && ((m_count + 32'd1) == m_cmp);
    m_count = exp_count(m_count, cwe, cwd, tk, hd);
    if (mwe) m_pend = 1'b0;
    else if (hit) m_pend = 1'b1;
    if (mwe) m_cmp = mwd;
    @(posedge clk);
    #2;
    check(tag, m_count, vis & m_pend, exp_lines(m_pend, rt));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250));
    m_count = 32'd1; m_cmp = 32'd0; m_pend = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 reset", 32'd1, 1'b0, 8'd0);
    // R2 plain counting
    cyc(1,0,0,0, 1,32'd100, 3'd2,1, "R2 cmp setup");
    for (int i = 0; i < 5; i++) cyc(1,0,0,0, 0,0, 3'd2,1, "R2 step");
    // R4 load while held, R3 hold keeps value and raises nothing
    cyc(1,1,1,32'h1234, 0,0, 3'd2,1, "R4 load held");
    cyc(0,0,0,0, 1,32'h1235, 3'd2,1, "R3 cmp next");
    for (int i = 0; i < 4; i++) cyc(1,1,0,0, 0,0, 3'd2,1, "R3 held no irq");
    // R4 load equal to compare raises nothing
    cyc(1,0,1,32'h1235, 0,0, 3'd2,1, "R4 load on compare");
    cyc(0,0,1,32'h1234, 0,0, 3'd2,1, "R4 reload");
    // R5 match
    cyc(1,0,0,0, 0,0, 3'd2,1, "R5 match");
    // R8 route move while pending
    cyc(1,0,0,0, 0,0, 3'd5,1, "R8 move");
    cyc(1,0,0,0, 0,0, 3'd7,1, "R8 move again");
    // R10 sticky
    cyc(0,1,1,32'h9, 0,0, 3'd7,1, "R10 sticky");
    // R9 hidden status
    cyc(1,0,0,0, 0,0, 3'd7,0, "R9 status off");
    // R7 acknowledge, then simultaneous match and write
    cyc(1,0,0,0, 1,32'h20, 3'd7,1, "R7 ack");
    cyc(0,0,1,32'h1F, 0,0, 3'd7,1, "R7 setup");
    cyc(1,0,0,0, 1,32'h20, 3'd1,1, "R7 write beats match");
    // R6 wrap
    cyc(0,0,1,32'hFFFF_FFFE, 1,32'h0, 3'd4,1, "R6 setup");
    cyc(1,0,0,0, 0,0, 3'd4,1, "R6 to all ones");
    cyc(1,0,0,0, 0,0, 3'd4,1, "R6 wrap match");
    cyc(1,0,0,0, 1,32'h5, 3'd4,1, "R6 ack");
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic tk, hd, cwe, mwe, vis;
      logic [31:0] cwd, mwd;
      tk  = ($urandom % 100) < 85;
      hd  = ($urandom % 100) < 15;
      cwe = ($urandom % 100) < 3;
      mwe = ($urandom % 100) < 6;
      vis = ($urandom % 100) < 90;
      cwd = ($urandom % 4 == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom;
      mwd = m_count + ($urandom % 24);
      cyc(tk, hd, cwe, cwd, mwe, mwd, 3'($urandom % 8), vis, "R5 R8 random");
    end
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule